// File: doc/BRIEF.md
# Parallel ADC Conversion and Readout Sequencer

This block sits on the host side of a 12-bit sampling converter that has a parallel output and takes an external conversion clock. The block produces that clock by dividing the system clock. When a start request arrives, it places a channel address on the converter's address lines. It then pulses an active-low write strobe, with chip select low, across a rising edge of the converter clock, so that a conversion begins.

After the write, the block waits for the converter's completion line to rise. It then lets a settling delay pass and drives chip select and read low together for long enough to cover the bus access time. It samples the 12-bit word at the end of that window. When the strobes have gone high again, the sample and its channel number appear together with a one-cycle valid pulse. If the completion line never rises, a watchdog counter reports a timeout and the block returns to idle.

Every timing figure is given in nanoseconds and turned into system-clock cycles by rounding up, so each minimum is met at whatever clock period is configured.

Top module: `adc_seq_ctrl`

## Requirements
- R1: During and right after reset, the block is in this state: `ready_o`=1, `adc_wr_no`=`adc_cs_no`=`adc_rd_no`=1, `adc_addr_o`=0, `adc_clk_o`=0, and `sample_valid_o`=`timeout_o`=0.
- R2: `adc_clk_o` is high for exactly HALF cycles and low for exactly HALF cycles. HALF is the larger of ceil(ADC_CLK_NS/2/Tclk) and ceil(ADC_HALF_MIN_NS/Tclk).
- R3: An accepted start latches `chan_i`. That value is driven on `adc_addr_o` for at least SETUP cycles before the write strobe falls. It stays unchanged while the strobe is low and is held for exactly HOLD cycles after the strobe rises. Outside this window `adc_addr_o` is 0.
- R4: `adc_wr_no` falls together with a falling edge of `adc_clk_o`, with `adc_cs_no` low and `adc_rd_no` high. It stays low for HALF+WRA cycles, so one rising edge of the converter clock lies inside the low window and WRA low cycles follow that edge.
- R5: Reading starts only after a low-to-high transition of `adc_busy_i`. It starts exactly POST+3 cycles after the transition: 2 cycles of synchronizer, 1 cycle of edge detection, then POST cycles of settling.
- R6: `adc_cs_no` and `adc_rd_no` fall together and stay low for exactly ACC cycles. `adc_data_i` is sampled at the clock edge that ends that window. ACC is the larger of ceil(ACCESS_NS/Tclk) and ceil(STROBE_MIN_NS/Tclk).
- R7: In the cycle after the strobes return high, `sample_valid_o` is high for exactly one cycle. In that cycle `sample_o` holds the sampled word, passed through unchanged in straight binary (0x000 is zero input, 0x800 is midscale, 0xFFF is full scale), and `sample_chan_o` holds the latched channel.
- R8: `ready_o` is high only when the block is idle. A start request while `ready_o` is low is ignored: it changes neither the channel in progress nor the number of conversions.
- R9: If no rising edge of `adc_busy_i` arrives within TIMEOUT_CYC cycles of the end of the address hold, `timeout_o` pulses for one cycle, exactly HOLD+TIMEOUT_CYC cycles after the write strobe rises. The block then returns to idle without a read and without a valid pulse.
- R10: SETUP, HOLD, WRA and POST each equal ceil(ns/Tclk) of their nanosecond parameter, with a minimum of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Conversion request, one cycle |
| chan_i | input | CH_W | Channel for the request |
| ready_o | output | 1 | Idle, a request will be accepted |
| adc_clk_o | output | 1 | Divided conversion clock to the converter |
| adc_addr_o | output | CH_W | Channel address to the converter |
| adc_wr_no | output | 1 | Write strobe, active low |
| adc_cs_no | output | 1 | Chip select, active low |
| adc_rd_no | output | 1 | Read enable, active low |
| adc_busy_i | input | 1 | Completion line, high when the result is ready |
| adc_data_i | input | DATA_W | Converter output bus |
| sample_o | output | DATA_W | Captured result |
| sample_chan_o | output | CH_W | Channel of the captured result |
| sample_valid_o | output | 1 | One-cycle pulse, sample presented |
| timeout_o | output | 1 | One-cycle pulse, completion never came |

## Verification
The converter model in the bench drives a different, deliberately wrong word on the bus for every cycle before the access time has passed. A capture made one cycle too early therefore returns a value that differs from the expected one. Random channels and data words check that address and result are carried through unchanged. The directed words 0x000, 0x800 and 0xFFF, on channels 0 and 7, cover the extremes of both fields. Random conversion lengths vary the moment the completion line rises, which separates a fixed-delay read from one that really waits for the edge. A run with the completion line held low, and a run with a second start issued during a conversion, test the timeout path and the rule that a start while busy is ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_EDGE,
    ST_WR,
    ST_HOLD,
    ST_WAIT,
    ST_POST,
    ST_READ,
    ST_DONE
  } seq_state_e;

  function automatic int unsigned ceil_div(int unsigned a, int unsigned b);
    return (a + b - 1) / b;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // ns minimum -> cycles, never below one
  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ps);
    return max2(ceil_div(ns * 1000, clk_ps), 1);
  endfunction

endpackage

// File: rtl/adc_conv_clk.sv
module adc_conv_clk #(
  parameter int unsigned HALF_CYC = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic adc_clk_o,
  output logic fall_next_o
);
  localparam int unsigned DW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [DW-1:0] div_q;
  logic          lvl_q;
  logic          wrap;

  assign wrap = (div_q == DW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q <= '0;
      lvl_q <= 1'b0;
    end else if (wrap) begin
      div_q <= '0;
      lvl_q <= ~lvl_q;
    end else begin
      div_q <= div_q + DW'(1);
    end
  end

  assign adc_clk_o   = lvl_q;
  assign fall_next_o = wrap & lvl_q;
endmodule

// File: rtl/adc_busy_edge.sv
module adc_busy_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  output logic rise_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], busy_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/adc_sample_reg.sv
module adc_sample_reg #(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CH_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_en_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [CH_W-1:0]   chan_i,
  output logic [DATA_W-1:0] sample_o,
  output logic [CH_W-1:0]   chan_o,
  output logic              valid_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      chan_o   <= '0;
      valid_o  <= 1'b0;
    end else begin
      if (cap_en_i) begin
        sample_o <= data_i;
        chan_o   <= chan_i;
      end
      valid_o <= done_i;
    end
  end
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned CH_W            = 3,
  parameter int unsigned DATA_W          = 12,
  parameter int unsigned CLK_PS          = 8000,
  parameter int unsigned ADC_CLK_NS      = 125,
  parameter int unsigned ADC_HALF_MIN_NS = 40,
  parameter int unsigned ADDR_SETUP_NS   = 10,
  parameter int unsigned ADDR_HOLD_NS    = 10,
  parameter int unsigned WR_AFTER_NS     = 20,
  parameter int unsigned POST_BUSY_NS    = 10,
  parameter int unsigned ACCESS_NS       = 30,
  parameter int unsigned STROBE_MIN_NS   = 25,
  parameter int unsigned TIMEOUT_CYC     = 4096
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CH_W-1:0]   chan_i,
  output logic              ready_o,
  output logic              adc_clk_o,
  output logic [CH_W-1:0]   adc_addr_o,
  output logic              adc_wr_no,
  output logic              adc_cs_no,
  output logic              adc_rd_no,
  input  logic              adc_busy_i,
  input  logic [DATA_W-1:0] adc_data_i,
  output logic [DATA_W-1:0] sample_o,
  output logic [CH_W-1:0]   sample_chan_o,
  output logic              sample_valid_o,
  output logic              timeout_o
);
  localparam int unsigned HALF_CYC  = max2(ceil_div(ADC_CLK_NS * 1000, 2 * CLK_PS),
                                           ns_to_cyc(ADC_HALF_MIN_NS, CLK_PS));
  localparam int unsigned SETUP_CYC = ns_to_cyc(ADDR_SETUP_NS, CLK_PS);
  localparam int unsigned HOLD_CYC  = ns_to_cyc(ADDR_HOLD_NS, CLK_PS);
  localparam int unsigned WR_CYC    = HALF_CYC + ns_to_cyc(WR_AFTER_NS, CLK_PS);
  localparam int unsigned POST_CYC  = ns_to_cyc(POST_BUSY_NS, CLK_PS);
  localparam int unsigned ACC_CYC   = max2(ns_to_cyc(ACCESS_NS, CLK_PS),
                                           ns_to_cyc(STROBE_MIN_NS, CLK_PS));
  localparam int unsigned CNT_MAX   = max2(max2(TIMEOUT_CYC, WR_CYC),
                                           max2(max2(SETUP_CYC, HOLD_CYC),
                                                max2(POST_CYC, ACC_CYC)));
  localparam int unsigned CNT_W     = $clog2(CNT_MAX + 1);

  typedef logic [CNT_W-1:0] cnt_t;

  seq_state_e      state_q, state_d;
  cnt_t            cnt_q, cnt_d;
  logic [CH_W-1:0] chan_q, chan_d;
  logic            to_q, to_d;
  logic            cnt_zero, cap_en, done;
  logic            fall_next, busy_rise, addr_drive;

  adc_conv_clk #(.HALF_CYC(HALF_CYC)) u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adc_clk_o  (adc_clk_o),
    .fall_next_o(fall_next)
  );

  adc_busy_edge #(.SYNC_STAGES(2)) u_busy (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .busy_i(adc_busy_i),
    .rise_o(busy_rise)
  );

  adc_sample_reg #(.DATA_W(DATA_W), .CH_W(CH_W)) u_cap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .cap_en_i(cap_en),
    .done_i  (done),
    .data_i  (adc_data_i),
    .chan_i  (chan_q),
    .sample_o(sample_o),
    .chan_o  (sample_chan_o),
    .valid_o (sample_valid_o)
  );

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    chan_d  = chan_q;
    to_d    = 1'b0;
    cap_en  = 1'b0;
    done    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) begin
        chan_d  = chan_i;
        cnt_d   = cnt_t'(SETUP_CYC - 1);
        state_d = ST_SETUP;
      end
      ST_SETUP: if (cnt_zero) state_d = ST_EDGE;
                else cnt_d = cnt_q - cnt_t'(1);
      // start write together with a converter clock fall
      ST_EDGE: if (fall_next) begin
        cnt_d   = cnt_t'(WR_CYC - 1);
        state_d = ST_WR;
      end
      ST_WR: if (cnt_zero) begin
        cnt_d   = cnt_t'(HOLD_CYC - 1);
        state_d = ST_HOLD;
      end else cnt_d = cnt_q - cnt_t'(1);
      ST_HOLD: if (cnt_zero) begin
        cnt_d   = cnt_t'(TIMEOUT_CYC - 1);
        state_d = ST_WAIT;
      end else cnt_d = cnt_q - cnt_t'(1);
      ST_WAIT: if (busy_rise) begin
        cnt_d   = cnt_t'(POST_CYC - 1);
        state_d = ST_POST;
      end else if (cnt_zero) begin
        to_d    = 1'b1;
        state_d = ST_IDLE;
      end else cnt_d = cnt_q - cnt_t'(1);
      ST_POST: if (cnt_zero) begin
        cnt_d   = cnt_t'(ACC_CYC - 1);
        state_d = ST_READ;
      end else cnt_d = cnt_q - cnt_t'(1);
      ST_READ: if (cnt_zero) begin
        cap_en  = 1'b1;
        state_d = ST_DONE;
      end else cnt_d = cnt_q - cnt_t'(1);
      ST_DONE: begin
        done    = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      chan_q  <= '0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      chan_q  <= chan_d;
      to_q    <= to_d;
    end
  end

  assign addr_drive = (state_q == ST_SETUP) || (state_q == ST_EDGE) ||
                      (state_q == ST_WR)    || (state_q == ST_HOLD);

  assign ready_o    = (state_q == ST_IDLE);
  assign adc_addr_o = addr_drive ? chan_q : '0;
  assign adc_wr_no  = (state_q != ST_WR);
  assign adc_rd_no  = (state_q != ST_READ);
  assign adc_cs_no  = !((state_q == ST_WR) || (state_q == ST_READ));
  assign timeout_o  = to_q;
endmodule

// File: rtl/adc_seq_ctrl_sva.sv
module adc_seq_ctrl_sva #(
  parameter int unsigned CH_W = 3
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic            ready_o,
  input logic [CH_W-1:0] adc_addr_o,
  input logic            adc_wr_no,
  input logic            adc_cs_no,
  input logic            adc_rd_no,
  input logic            sample_valid_o,
  input logic            timeout_o
);
  a_r1_idle_strobes_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (adc_wr_no && adc_cs_no && adc_rd_no));

  a_r6_read_under_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_rd_no |-> !adc_cs_no);

  a_r4_write_not_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_wr_no |-> (adc_rd_no && !adc_cs_no));

  a_r3_addr_stable_in_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adc_wr_no |-> $stable(adc_addr_o));

  a_r7_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_valid_o |=> !sample_valid_o);

  a_r9_timeout_to_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> (ready_o && !sample_valid_o));

  a_r8_accept_drops_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && ready_o) |=> !ready_o);
endmodule

bind adc_seq_ctrl adc_seq_ctrl_sva #(.CH_W(CH_W)) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .start_i       (start_i),
  .ready_o       (ready_o),
  .adc_addr_o    (adc_addr_o),
  .adc_wr_no     (adc_wr_no),
  .adc_cs_no     (adc_cs_no),
  .adc_rd_no     (adc_rd_no),
  .sample_valid_o(sample_valid_o),
  .timeout_o     (timeout_o)
);

// File: tb/sim_adc_seq_ctrl.sv
module sim_adc_seq_ctrl;
  localparam int CH_W = 3;
  localparam int DW   = 12;
  localparam int TCLK_PS = 8000;
  localparam int TO_CYC  = 600;

  function automatic int cyc(int ns);
    int c;
    c = (ns * 1000 + TCLK_PS - 1) / TCLK_PS;
    return (c < 1) ? 1 : c;
  endfunction

  // expected counts from the ns figures (R10)
  localparam int E_HALF  = ((125000 + 2*TCLK_PS - 1) / (2*TCLK_PS) > 5) ? (125000 + 2*TCLK_PS - 1) / (2*TCLK_PS) : 5;
  localparam int E_SETUP = 2;
  localparam int E_HOLD  = 2;
  localparam int E_WRA   = 3;
  localparam int E_POST  = 2;
  localparam int E_ACC   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [CH_W-1:0] chan = '0;
  logic ready, adc_clk, wr_n, cs_n, rd_n, valid, tout;
  logic [CH_W-1:0] addr, s_chan;
  logic [DW-1:0] s_data;
  logic busy = 1'b1;
  logic [DW-1:0] bus = '0;

  always #4 clk = ~clk;

  adc_seq_ctrl #(.TIMEOUT_CYC(TO_CYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .chan_i(chan), .ready_o(ready),
    .adc_clk_o(adc_clk), .adc_addr_o(addr), .adc_wr_no(wr_n), .adc_cs_no(cs_n),
    .adc_rd_no(rd_n), .adc_busy_i(busy), .adc_data_i(bus), .sample_o(s_data),
    .sample_chan_o(s_chan), .sample_valid_o(valid), .timeout_o(tout)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and monitors
  logic [DW-1:0] cur_data = '0;
  bit  drop_busy = 0;
  int  conv_cyc = 219;
  int  conv_timer = 0, conv_seen = 0;
  logic [CH_W-1:0] conv_addr = '0;
  logic clk_prev = 1'b0;
  int  run = 0, hi_len = 0, lo_len = 0;
  int  wr_run = 0, wr_hi = 0, wr_w = 0, wr_after = 0;
  bit  wr_prev_low = 0, seen_wr = 0;
  int  setup_n = 0, hold_n = 0;
  int  lowcnt = 0, rd_w = 0, overlap = 0;
  bit  lat_on = 0; int lat = 0, post_lat = 0;
  bit  ws_on = 0;  int ws = 0, to_lat = 0;
  int  vcnt = 0, tocnt = 0; bit vwide = 0, valid_prev = 0;
  logic [DW-1:0] got_d = '0; logic [CH_W-1:0] got_c = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (adc_clk == clk_prev) run++;
      else begin
        if (clk_prev) hi_len = run; else lo_len = run;
        run = 1;
      end
      if (lat_on) begin
        lat++;
        if (!cs_n && !rd_n) begin post_lat = lat; lat_on = 0; end
      end
      if (adc_clk && !clk_prev && !wr_n && !cs_n) begin
        conv_addr = addr; busy = 1'b0; conv_timer = conv_cyc; conv_seen++;
      end else if (conv_timer > 0) begin
        conv_timer--;
        if (conv_timer == 0 && !drop_busy) begin busy = 1'b1; lat_on = 1; lat = 0; end
      end
      clk_prev = adc_clk;
      if (ws_on) ws++;
      if (!wr_n) begin
        wr_run++;
        if (adc_clk) wr_hi++;
      end else if (wr_prev_low) begin
        wr_w = wr_run; wr_after = wr_hi; wr_run = 0; wr_hi = 0;
        seen_wr = 1; ws_on = 1; ws = 0;
      end
      wr_prev_low = !wr_n;
      if (addr != '0 && wr_n) begin
        if (seen_wr) hold_n++; else setup_n++;
      end
      if (!cs_n && !rd_n) lowcnt++;
      else begin
        if (lowcnt > 0) rd_w = lowcnt;
        lowcnt = 0;
      end
      if (!rd_n && !wr_n) overlap++;
      bus = (lowcnt >= E_ACC) ? cur_data : (cur_data ^ DW'($urandom_range(1, 4095)));
      if (valid) begin
        vcnt++; got_d = s_data; got_c = s_chan;
        if (valid_prev) vwide = 1;
      end
      valid_prev = valid;
      if (tout) begin tocnt++; to_lat = ws; end
    end
  end

  task automatic run_conv(input logic [CH_W-1:0] ch, input logic [DW-1:0] d,
                          input bit drop, input bit poke);
    int guard;
    int seen0;
    guard = 0;
    while (!ready && guard < 2000) begin @(negedge clk); guard++; end
    cur_data = d; drop_busy = drop; conv_cyc = 200 + $urandom_range(0, 60);
    seen_wr = 0; setup_n = 0; hold_n = 0; vcnt = 0; tocnt = 0; vwide = 0;
    ws_on = 0; post_lat = -1; rd_w = 0; overlap = 0;
    seen0 = conv_seen;
    start = 1'b1; chan = ch;
    @(negedge clk);
    start = 1'b0;
    chk(!ready, "R8 ready low after accept", int'(ready), 0);
    if (poke) begin
      repeat (40) @(negedge clk);
      chk(!ready, "R8 ready low mid-cycle", int'(ready), 0);
      start = 1'b1; chan = ch ^ 3'd3;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (!(ready && (vcnt > 0 || tocnt > 0)) && guard < 3000) begin
      @(negedge clk); guard++;
    end
    repeat (2) @(negedge clk);
    if (!drop) begin
      chk(vcnt == 1 && !vwide, "R7 one valid pulse", vcnt, 1);
      chk(got_d == d, "R6 sampled word", int'(got_d), int'(d));
      chk(got_c == ch, "R7 channel with sample", int'(got_c), int'(ch));
      chk(conv_addr == ch, "R3 address seen by converter", int'(conv_addr), int'(ch));
      chk(wr_w == E_HALF + E_WRA, "R4 write low width", wr_w, E_HALF + E_WRA);
      chk(wr_after == E_WRA, "R4 R10 write low after rise", wr_after, E_WRA);
      if (ch != '0) begin
        chk(setup_n >= E_SETUP, "R3 R10 address setup", setup_n, E_SETUP);
        chk(hold_n == E_HOLD, "R3 R10 address hold", hold_n, E_HOLD);
      end
      chk(post_lat == E_POST + 3, "R5 R10 busy to read", post_lat, E_POST + 3);
      chk(rd_w == E_ACC, "R6 read low width", rd_w, E_ACC);
      chk(overlap == 0, "R4 write and read overlap", overlap, 0);
      chk(tocnt == 0, "R9 no timeout", tocnt, 0);
      chk(conv_seen == seen0 + 1, "R8 conversions started", conv_seen, seen0 + 1);
    end else begin
      chk(tocnt == 1, "R9 timeout pulse", tocnt, 1);
      chk(vcnt == 0, "R9 no valid on timeout", vcnt, 0);
      chk(to_lat == E_HOLD + TO_CYC, "R9 timeout latency", to_lat, E_HOLD + TO_CYC);
      chk(ready && cs_n && rd_n, "R9 idle after timeout", int'(ready), 1);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(ready && wr_n && cs_n && rd_n, "R1 strobes and ready in reset", int'({ready, wr_n, cs_n, rd_n}), 15);
    chk(!valid && !tout && !adc_clk && addr == '0, "R1 outputs low in reset", int'({valid, tout, adc_clk}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ready && !valid, "R1 ready after reset", int'(ready), 1);

    run_conv(3'd5, 12'h5A3, 0, 0);
    chk(hi_len == E_HALF, "R2 clock high time", hi_len, E_HALF);
    chk(lo_len == E_HALF, "R2 clock low time", lo_len, E_HALF);

    // straight-binary corners and channel extremes (R7)
    run_conv(3'd0, 12'h000, 0, 0);
    run_conv(3'd7, 12'hFFF, 0, 0);
    run_conv(3'd1, 12'h800, 0, 0);
    run_conv(3'd6, 12'h7FF, 0, 0);

    // completion never arrives (R9)
    run_conv(3'd2, 12'h123, 1, 0);
    run_conv(3'd4, 12'hABC, 0, 0);

    // start while busy is ignored (R8)
    run_conv(3'd4, 12'h3C3, 0, 1);
    begin
      int seen_before;
      seen_before = conv_seen;
      repeat (50) @(negedge clk);
      chk(conv_seen == seen_before && ready, "R8 ignored start caused no conversion", conv_seen, seen_before);
    end

    for (int i = 0; i < 20; i++) begin
      run_conv(CH_W'($urandom_range(1, 7)), DW'($urandom_range(0, 4095)), 0, 0);
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run hung, actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule